// File: doc/BRIEF.md
# Open-Drain Capable GPIO Controller

A general-purpose I/O block for 32 pins, controlled through a simple memory-mapped register port with a 32-bit address and 32-bit data. Three per-pin control registers set the pin behaviour: an output level, a drive enable and an open-drain select. A read-only register returns the synchronised pin levels. Per-pin pad logic turns the three control bits into a pad output value and a pad output enable. The physical tri-state buffers are outside the block, which exposes separate out, enable and in vectors.

Pins are numbered MSB-first in every register. Pin n sits at register bit (31 - n). The pad vectors are indexed by pin number, so `pad_out[0]` belongs to register bit 31. When open-drain is selected for a pin, it overrides the drive enable. In that mode the pin pulls low for an output bit of 0 and floats for an output bit of 1. The host changes single bits by read-modify-write of whole registers. The block has no atomic set or clear.

Top module: `odgpio_ctrl`

## Requirements
- R1: After reset, the output, drive-enable and open-drain registers all read 0, and every `pad_oe` bit is 0.
- R2: A write strobe stores the full 32-bit `wdata` into the output register (offset 0x00), the drive-enable register (0x04) or the open-drain register (0x18). A later read of the same offset returns that value.
- R3: Register bit (31 - n) controls pin n, and `pad_out[n]`, `pad_oe[n]` and `pad_in[n]` all belong to pin n. Pin 0 is therefore register bit 31.
- R4: A pin whose open-drain bit is 0 and whose drive-enable bit is 0 has `pad_oe` = 0, whatever its output bit holds.
- R5: A pin whose open-drain bit is 0 and whose drive-enable bit is 1 has `pad_oe` = 1 and `pad_out` equal to its output bit.
- R6: A pin whose open-drain bit is 1 and whose output bit is 0 has `pad_oe` = 1 and `pad_out` = 0, whatever its drive-enable bit holds.
- R7: A pin whose open-drain bit is 1 and whose output bit is 1 has `pad_oe` = 0, whatever its drive-enable bit holds.
- R8: A read at offset 0x1C returns the pin levels through a two-flop synchroniser. Take a `pad_in` change set up before clock edge k. A read strobe sampled at edge k+1 still returns the old level, and one sampled at edge k+2 returns the new level.
- R9: A write to offset 0x1C changes no register and no pad output.
- R10: Every other address reads as 0 and ignores writes. This covers the unlisted offsets inside the 0x80-byte window, offsets that are not word aligned, and addresses at or above 0x80.
- R11: `rdata` is registered. It takes the addressed value on the clock edge that samples `rd_en`, and it holds its value on edges where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after `rd_en` |
| pad_in | input | 32 | Pin levels from the pads, indexed by pin |
| pad_out | output | 32 | Pad output values, indexed by pin |
| pad_oe | output | 32 | Pad output enables, indexed by pin |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 32-bit address and the 0x80-byte window at the listed offsets. All 32 pins therefore take part, so pin 0 at bit 31 and pin 31 at bit 0 are both checked against the bit-reversed pad mapping. The full address width lets the bench test out-of-window addresses as well as reserved offsets inside the window. Random control words give every pin all eight combinations of output, drive-enable and open-drain bits.

// File: rtl/odgpio_ctrl.sv
`timescale 1ns/1ps
module odgpio_ctrl #(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int OFF_OUT  = 'h00,
  parameter int OFF_DRV  = 'h04,
  parameter int OFF_ODS  = 'h18,
  parameter int OFF_LVL  = 'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe
);
  localparam int NPIN = DW;

  logic [DW-1:0] out_q, drv_q, ods_q;
  logic [NPIN-1:0] sync1_q, sync2_q;
  logic [DW-1:0] lvl_word;
  logic [DW-1:0] rd_mux;

  wire hit_out = (addr == AW'(OFF_OUT));
  wire hit_drv = (addr == AW'(OFF_DRV));
  wire hit_ods = (addr == AW'(OFF_ODS));
  wire hit_lvl = (addr == AW'(OFF_LVL));
  wire hit_any = hit_out | hit_drv | hit_ods | hit_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      drv_q <= '0;
      ods_q <= '0;
    end else if (wr_en) begin
      if (hit_out) out_q <= wdata;
      if (hit_drv) drv_q <= wdata;
      if (hit_ods) ods_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_out) rd_mux = out_q;
    if (hit_drv) rd_mux = drv_q;
    if (hit_ods) rd_mux = ods_q;
    if (hit_lvl) rd_mux = lvl_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    localparam int B = DW - 1 - n;
    assign lvl_word[B] = sync2_q[n];
    assign pad_out[n]  = ods_q[B] ? 1'b0 : out_q[B];
    assign pad_oe[n]   = ods_q[B] ? ~out_q[B] : drv_q[B];
  end

  AST_WR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit_out |=> out_q == $past(wdata)); // R2
  AST_LVL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit_lvl |=> $stable(out_q) && $stable(drv_q) && $stable(ods_q)); // R9
  AST_RSVD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !hit_any |=> $stable(out_q) && $stable(drv_q) && $stable(ods_q)); // R10
  AST_RSVD_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !hit_any |=> rdata == '0); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & {<<{ods_q}}) == '0); // R6
  AST_SYNC_2FF: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pad_in) && $past($stable(pad_in)) |-> sync2_q == pad_in); // R8
endmodule

// File: tb/odgpio_ctrl_tb.sv
`timescale 1ns/1ps
module odgpio_ctrl_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [31:0] addr = 0, wdata = 0, pad_in = 0;
  logic [31:0] rdata, pad_out, pad_oe;
  int vectors = 0, miscompares = 0;
  logic [31:0] m_out = 0, m_drv = 0, m_ods = 0;

  always #2.5 clk = ~clk;

  odgpio_ctrl dut_i (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
                     .pad_in, .pad_out, .pad_oe);

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction
  function automatic logic [31:0] exp_oe(input logic [31:0] o, d, s);
    for (int n = 0; n < 32; n++)
      exp_oe[n] = s[31-n] ? !o[31-n] : d[31-n];
  endfunction
  function automatic logic [31:0] exp_out(input logic [31:0] o, s);
    for (int n = 0; n < 32; n++)
      exp_out[n] = s[31-n] ? 1'b0 : o[31-n];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    if (a == 32'h00) m_out = d;
    if (a == 32'h04) m_drv = d;
    if (a == 32'h18) m_ods = d;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic check_pads(input string req);
    chk({req, " pad_oe"}, pad_oe, exp_oe(m_out, m_drv, m_ods));
    chk({req, " pad_out"}, pad_out & pad_oe,
        exp_out(m_out, m_ods) & exp_oe(m_out, m_drv, m_ods));
  endtask

  task automatic check_regs(input string req);
    logic [31:0] d;
    rd(32'h00, d); chk({req, " out reg"}, d, m_out);
    rd(32'h04, d); chk({req, " drv reg"}, d, m_drv);
    rd(32'h18, d); chk({req, " ods reg"}, d, m_ods);
  endtask

  initial begin
    #500000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d, a, hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pad_oe after reset", pad_oe, 32'h0);
    check_regs("R1");

    // R3/R5: pin 0 is bit 31, driven
    wr(32'h04, 32'h8000_0000); wr(32'h00, 32'h8000_0000);
    chk("R3 pin0 oe", pad_oe, 32'h0000_0001);
    chk("R5 pin0 out", pad_out, 32'h0000_0001);
    // R4: drive off -> hi-z regardless of output
    wr(32'h04, 32'h0); chk("R4 hi-z", pad_oe, 32'h0);
    // R6/R7: open-drain overrides drive enable
    wr(32'h04, 32'hFFFF_FFFF); wr(32'h18, 32'hFFFF_FFFF);
    wr(32'h00, 32'h0000_0001);
    chk("R6 od low oe", pad_oe, 32'h7FFF_FFFF);
    chk("R6 od low out", pad_out, 32'h0);
    chk("R7 od float pin31", pad_oe[31], 1'b0);
    check_regs("R2");

    // R9: write to level register ignored
    wr(32'h1C, 32'h1234_5678); check_regs("R9"); check_pads("R9");
    // R10: reserved offsets
    wr(32'h08, 32'hDEAD_BEEF); wr(32'h01, 32'hDEAD_BEEF); wr(32'h100, 32'hDEAD_BEEF);
    check_regs("R10"); check_pads("R10");
    rd(32'h7C, d); chk("R10 read rsvd", d, 32'h0);
    rd(32'h80, d); chk("R10 read out-of-window", d, 32'h0);
    rd(32'h19, d); chk("R10 read unaligned", d, 32'h0);

    // R11: rdata holds without strobe
    rd(32'h00, d); hold = d;
    @(negedge clk); addr = 32'h04; @(negedge clk);
    chk("R11 rdata hold", rdata, hold);

    // R8: two-flop latency
    @(negedge clk); pad_in = 32'hA5A5_0F0F;        // before edge k
    @(negedge clk); rd_en = 1; addr = 32'h1C;      // sampled edge k+1
    @(negedge clk);
    chk("R8 one cycle old", rdata, 32'h0);         // edge k+1 still old
    @(negedge clk); rd_en = 0;                      // sampled edge k+2
    chk("R8 two cycle new", rdata, rev(32'hA5A5_0F0F));

    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 5);
      d = $urandom;
      case (sel)
        0: a = 32'h00; 1: a = 32'h04; 2: a = 32'h18; 3: a = 32'h1C;
        4: begin
             a = $urandom_range(0, 127);
             if (a == 0 || a == 4 || a == 'h18 || a == 'h1C) a = 32'h7C;
           end
        default: a = $urandom | 32'h80;
      endcase
      wr(a, d);
      check_pads("R4-7 random");
      if (it % 8 == 0) check_regs("R2 random");
      if (it % 16 == 0) begin
        pad_in = $urandom;
        repeat (2) @(negedge clk);
        rd(32'h1C, d); chk("R8 random level", d, rev(pad_in));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule